// File: doc/BRIEF.md
# Coherent Read Snoop Router

This block sits between two processor clusters and serves a coherent line read from one of them. The requesting cluster presents a line address on an AXI-style read-address channel. The router first asks the peer cluster's cache for the line over a dedicated snoop-address channel. The peer answers on a snoop-response channel. If the peer holds the line, it streams the line over a snoop-data channel, and the router forwards each beat to the requester's read-data channel. If the peer does not hold the line, the router reads the line from a downstream memory port and forwards that data instead.

Only one coherent read is handled at a time. A line is 64 bytes, carried as four 128-bit beats. The final beat is flagged, and it carries an error code when the peer reported a snoop error. Every channel uses a valid/ready handshake.

Top module: `coh_read_router`

## Requirements
- R1: While reset is held and on the first cycle after it, `snp_ac_valid_o`, `mem_ar_valid_o` and `req_r_valid_o` are low, and `req_ar_ready_o` is high.
- R2: After accepting a request, the router raises `snp_ac_valid_o` with the request address with its low 6 bits cleared. Valid and address stay stable until `snp_ac_ready_i` is seen high.
- R3: After the snoop address is accepted, the router asserts `snp_cr_ready_o`. A response with bit 0 set (hit) makes the router forward the four snoop-data beats unchanged and in order to `req_r_data_o`. `mem_ar_valid_o` stays low for the whole request.
- R4: A response with bit 0 clear (miss) makes the router raise `mem_ar_valid_o` with the line-aligned address and forward the four memory beats. During that time `snp_cd_ready_o` stays low, and any snoop-data traffic has no effect on `req_r_data_o`.
- R5: `req_r_last_o` is high on the fourth beat of a line and low on the first three.
- R6: Response bit 1 (error) makes `req_r_resp_o` equal 2'b10 on the final beat only. All other beats, and every beat of a request without the error bit, carry 2'b00.
- R7: `req_ar_ready_o` is low from the cycle after a request is accepted until one cycle after the final read-data beat is accepted. It is high again on the following cycle.
- R8: While `req_r_ready_i` is low, the ready of the selected data source is low, and `req_r_valid_o` and `req_r_data_o` hold their values.
- R9: `mem_ar_valid_o` and `mem_ar_addr_o` stay stable until `mem_ar_ready_i` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ar_valid_i | input | 1 | Requester read-address valid |
| req_ar_ready_o | output | 1 | Requester read-address ready |
| req_ar_addr_i | input | ADDR_W | Requested address |
| req_r_valid_o | output | 1 | Read-data valid to the requester |
| req_r_ready_i | input | 1 | Requester accepts read data |
| req_r_data_o | output | DATA_W | Read-data beat |
| req_r_resp_o | output | 2 | Beat response code, 00 okay, 10 error |
| req_r_last_o | output | 1 | Final beat of the line |
| snp_ac_valid_o | output | 1 | Snoop-address valid to the peer |
| snp_ac_ready_i | input | 1 | Peer accepts the snoop address |
| snp_ac_addr_o | output | ADDR_W | Line-aligned snoop address |
| snp_cr_valid_i | input | 1 | Snoop-response valid |
| snp_cr_ready_o | output | 1 | Router accepts the snoop response |
| snp_cr_resp_i | input | 2 | Bit 0 hit, bit 1 error |
| snp_cd_valid_i | input | 1 | Snoop-data valid |
| snp_cd_ready_o | output | 1 | Router accepts snoop data |
| snp_cd_data_i | input | DATA_W | Snoop-data beat |
| mem_ar_valid_o | output | 1 | Memory read-address valid |
| mem_ar_ready_i | input | 1 | Memory accepts the address |
| mem_ar_addr_o | output | ADDR_W | Line-aligned memory address |
| mem_r_valid_i | input | 1 | Memory data valid |
| mem_r_ready_o | output | 1 | Router accepts memory data |
| mem_r_data_i | input | DATA_W | Memory data beat |

## Verification
Two events can fall in the same cycle: a new request waiting on the request channel, and the final data beat of the current line being accepted. The bench provokes this by keeping `req_ar_valid_i` high with a second address for the whole first transfer. It then checks three things:
- the ready stays low through every beat and through the turnaround cycle;
- the first line's data and last flag arrive intact;
- the second snoop address appears only after the turnaround.

Requester backpressure in the middle of a line is applied in a separate run. There the bench checks that the source ready drops while the beat on the output holds still.

// File: rtl/coh_router_pkg.sv
package coh_router_pkg;
  localparam int SNP_RESP_W = 2;
  localparam int SNP_HIT_BIT = 0;
  localparam int SNP_ERR_BIT = 1;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNP_ADDR,
    ST_SNP_RESP,
    ST_SNP_DATA,
    ST_MEM_ADDR,
    ST_MEM_DATA,
    ST_RESP
  } state_e;
endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_router_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int OFFS_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  output logic                  req_ready_o,
  input  logic                  snp_ac_ready_i,
  input  logic                  snp_cr_valid_i,
  input  logic [SNP_RESP_W-1:0] snp_cr_resp_i,
  input  logic                  mem_ar_ready_i,
  input  logic                  line_done_i,
  output logic                  snp_ac_valid_o,
  output logic                  snp_cr_ready_o,
  output logic                  mem_ar_valid_o,
  output logic [ADDR_W-1:0]     line_addr_o,
  output logic                  sel_snp_o,
  output logic                  sel_mem_o,
  output logic                  err_o
);
  state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_SNP_ADDR;
      ST_SNP_ADDR: if (snp_ac_ready_i) state_d = ST_SNP_RESP;
      ST_SNP_RESP: if (snp_cr_valid_i)
                     state_d = snp_cr_resp_i[SNP_HIT_BIT] ? ST_SNP_DATA : ST_MEM_ADDR;
      ST_MEM_ADDR: if (mem_ar_ready_i) state_d = ST_MEM_DATA;
      ST_SNP_DATA,
      ST_MEM_DATA: if (line_done_i) state_d = ST_RESP;
      ST_RESP:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i)
        addr_q <= {req_addr_i[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
      if (state_q == ST_SNP_RESP && snp_cr_valid_i)
        err_q <= snp_cr_resp_i[SNP_ERR_BIT];
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign snp_ac_valid_o = (state_q == ST_SNP_ADDR);
  assign snp_cr_ready_o = (state_q == ST_SNP_RESP);
  assign mem_ar_valid_o = (state_q == ST_MEM_ADDR);
  assign sel_snp_o      = (state_q == ST_SNP_DATA);
  assign sel_mem_o      = (state_q == ST_MEM_DATA);
  assign line_addr_o    = addr_q;
  assign err_o          = err_q;
endmodule

// File: rtl/coh_beat_mux.sv
module coh_beat_mux
  import coh_router_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int BEATS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_snp_i,
  input  logic              sel_mem_i,
  input  logic              err_i,
  input  logic              snp_valid_i,
  input  logic [DATA_W-1:0] snp_data_i,
  output logic              snp_ready_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [1:0]        out_resp_o,
  output logic              out_last_o,
  output logic              line_done_o
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic xfer, final_beat;

  // straight pass-through; the source owns the stability rule
  assign out_valid_o = (sel_snp_i & snp_valid_i) | (sel_mem_i & mem_valid_i);
  assign out_data_o  = sel_snp_i ? snp_data_i : (sel_mem_i ? mem_data_i : '0);
  assign snp_ready_o = sel_snp_i & out_ready_i;
  assign mem_ready_o = sel_mem_i & out_ready_i;
  assign xfer        = out_valid_o & out_ready_i;

  generate
    if (BEATS > 1) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= '0;
        else if (xfer) cnt_q <= final_beat ? '0 : cnt_q + 1'b1;
      end
      assign final_beat = (cnt_q == CNT_W'(BEATS - 1));
    end else begin : g_single
      assign final_beat = 1'b1;
    end
  endgenerate

  assign out_last_o  = out_valid_o & final_beat;
  assign out_resp_o  = (out_last_o && err_i) ? RESP_SLVERR : RESP_OKAY;
  assign line_done_o = xfer & final_beat;
endmodule

// File: rtl/coh_read_router.sv
module coh_read_router
  import coh_router_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 128,
  parameter int LINE_BYTES = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_ar_valid_i,
  output logic                  req_ar_ready_o,
  input  logic [ADDR_W-1:0]     req_ar_addr_i,
  output logic                  req_r_valid_o,
  input  logic                  req_r_ready_i,
  output logic [DATA_W-1:0]     req_r_data_o,
  output logic [1:0]            req_r_resp_o,
  output logic                  req_r_last_o,
  output logic                  snp_ac_valid_o,
  input  logic                  snp_ac_ready_i,
  output logic [ADDR_W-1:0]     snp_ac_addr_o,
  input  logic                  snp_cr_valid_i,
  output logic                  snp_cr_ready_o,
  input  logic [SNP_RESP_W-1:0] snp_cr_resp_i,
  input  logic                  snp_cd_valid_i,
  output logic                  snp_cd_ready_o,
  input  logic [DATA_W-1:0]     snp_cd_data_i,
  output logic                  mem_ar_valid_o,
  input  logic                  mem_ar_ready_i,
  output logic [ADDR_W-1:0]     mem_ar_addr_o,
  input  logic                  mem_r_valid_i,
  output logic                  mem_r_ready_o,
  input  logic [DATA_W-1:0]     mem_r_data_i
);
  localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
  localparam int OFFS_W = $clog2(LINE_BYTES);

  logic sel_snp, sel_mem, err, line_done;
  logic [ADDR_W-1:0] line_addr;

  coh_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i   (req_ar_valid_i),
    .req_addr_i    (req_ar_addr_i),
    .req_ready_o   (req_ar_ready_o),
    .snp_ac_ready_i,
    .snp_cr_valid_i,
    .snp_cr_resp_i,
    .mem_ar_ready_i,
    .line_done_i   (line_done),
    .snp_ac_valid_o,
    .snp_cr_ready_o,
    .mem_ar_valid_o,
    .line_addr_o   (line_addr),
    .sel_snp_o     (sel_snp),
    .sel_mem_o     (sel_mem),
    .err_o         (err)
  );

  coh_beat_mux #(.DATA_W(DATA_W), .BEATS(BEATS)) i_mux (
    .clk_i, .rst_ni,
    .sel_snp_i   (sel_snp),
    .sel_mem_i   (sel_mem),
    .err_i       (err),
    .snp_valid_i (snp_cd_valid_i),
    .snp_data_i  (snp_cd_data_i),
    .snp_ready_o (snp_cd_ready_o),
    .mem_valid_i (mem_r_valid_i),
    .mem_data_i  (mem_r_data_i),
    .mem_ready_o (mem_r_ready_o),
    .out_valid_o (req_r_valid_o),
    .out_ready_i (req_r_ready_i),
    .out_data_o  (req_r_data_o),
    .out_resp_o  (req_r_resp_o),
    .out_last_o  (req_r_last_o),
    .line_done_o (line_done)
  );

  assign snp_ac_addr_o = line_addr;
  assign mem_ar_addr_o = line_addr;
endmodule

// File: rtl/coh_read_router_chk.sv
module coh_read_router_chk
  import coh_router_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 128,
  parameter int BEATS  = 4,
  parameter int OFFS_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ar_valid_i,
  input logic              req_ar_ready_o,
  input logic              snp_ac_valid_o,
  input logic              snp_ac_ready_i,
  input logic [ADDR_W-1:0] snp_ac_addr_o,
  input logic              snp_cr_valid_i,
  input logic              snp_cr_ready_o,
  input logic [1:0]        snp_cr_resp_i,
  input logic              mem_ar_valid_o,
  input logic              mem_ar_ready_i,
  input logic [ADDR_W-1:0] mem_ar_addr_o,
  input logic              req_r_valid_o,
  input logic              req_r_ready_i,
  input logic [DATA_W-1:0] req_r_data_o,
  input logic [1:0]        req_r_resp_o,
  input logic              req_r_last_o,
  input logic              snp_cd_ready_o,
  input logic              mem_r_ready_o
);
  logic hit_seen_q;
  logic [15:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_seen_q <= 1'b0;
      beat_q     <= '0;
    end else begin
      if (req_ar_valid_i && req_ar_ready_o) hit_seen_q <= 1'b0;
      else if (snp_cr_valid_i && snp_cr_ready_o && snp_cr_resp_i[SNP_HIT_BIT]) hit_seen_q <= 1'b1;
      if (req_r_valid_o && req_r_ready_i) beat_q <= req_r_last_o ? '0 : beat_q + 16'd1;
    end
  end

  always @(posedge clk_i)
    if (!rst_ni)
      a_reset_quiet_r1: assert (!snp_ac_valid_o && !mem_ar_valid_o && !req_r_valid_o && req_ar_ready_o);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ar_ready_o |-> !snp_ac_valid_o && !mem_ar_valid_o && !req_r_valid_o);
  p_ac_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_ac_valid_o && !snp_ac_ready_i |=> snp_ac_valid_o && $stable(snp_ac_addr_o));
  p_ac_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_ac_valid_o |-> snp_ac_addr_o[OFFS_W-1:0] == '0);
  p_no_mem_on_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_seen_q |-> !mem_ar_valid_o);
  p_one_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_cd_ready_o && mem_r_ready_o));
  p_last_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_r_valid_o |-> req_r_last_o == (beat_q == 16'(BEATS - 1)));
  p_resp_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_r_valid_o && !req_r_last_o |-> req_r_resp_o == RESP_OKAY);
  p_r_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_r_valid_o && !req_r_ready_i |=> req_r_valid_o && $stable(req_r_data_o));
  p_src_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_r_ready_i |-> !snp_cd_ready_o && !mem_r_ready_o);
  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ar_valid_o && !mem_ar_ready_i |=> mem_ar_valid_o && $stable(mem_ar_addr_o));
endmodule

bind coh_read_router coh_read_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .OFFS_W(OFFS_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_ar_valid_i(req_ar_valid_i), .req_ar_ready_o(req_ar_ready_o),
  .snp_ac_valid_o(snp_ac_valid_o), .snp_ac_ready_i(snp_ac_ready_i),
  .snp_ac_addr_o(snp_ac_addr_o),
  .snp_cr_valid_i(snp_cr_valid_i), .snp_cr_ready_o(snp_cr_ready_o),
  .snp_cr_resp_i(snp_cr_resp_i),
  .mem_ar_valid_o(mem_ar_valid_o), .mem_ar_ready_i(mem_ar_ready_i),
  .mem_ar_addr_o(mem_ar_addr_o),
  .req_r_valid_o(req_r_valid_o), .req_r_ready_i(req_r_ready_i),
  .req_r_data_o(req_r_data_o), .req_r_resp_o(req_r_resp_o),
  .req_r_last_o(req_r_last_o),
  .snp_cd_ready_o(snp_cd_ready_o), .mem_r_ready_o(mem_r_ready_o)
);

// File: tb/test_coh_read_router.sv
`timescale 1ns/1ps
module test_coh_read_router;
  localparam int AW = 40;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_ar_valid = 0, req_ar_ready;
  logic [AW-1:0] req_ar_addr = '0;
  logic          req_r_valid, req_r_ready = 0;
  logic [DW-1:0] req_r_data;
  logic [1:0]    req_r_resp;
  logic          req_r_last;
  logic          snp_ac_valid, snp_ac_ready = 0;
  logic [AW-1:0] snp_ac_addr;
  logic          snp_cr_valid = 0, snp_cr_ready;
  logic [1:0]    snp_cr_resp = '0;
  logic          snp_cd_valid = 0, snp_cd_ready;
  logic [DW-1:0] snp_cd_data = '0;
  logic          mem_ar_valid, mem_ar_ready = 0;
  logic [AW-1:0] mem_ar_addr;
  logic          mem_r_valid = 0, mem_r_ready;
  logic [DW-1:0] mem_r_data = '0;

  int checks = 0;
  int errors = 0;

  coh_read_router i_coh_read_router (
    .clk_i(clk), .rst_ni(rst_n),
    .req_ar_valid_i(req_ar_valid), .req_ar_ready_o(req_ar_ready), .req_ar_addr_i(req_ar_addr),
    .req_r_valid_o(req_r_valid), .req_r_ready_i(req_r_ready), .req_r_data_o(req_r_data),
    .req_r_resp_o(req_r_resp), .req_r_last_o(req_r_last),
    .snp_ac_valid_o(snp_ac_valid), .snp_ac_ready_i(snp_ac_ready), .snp_ac_addr_o(snp_ac_addr),
    .snp_cr_valid_i(snp_cr_valid), .snp_cr_ready_o(snp_cr_ready), .snp_cr_resp_i(snp_cr_resp),
    .snp_cd_valid_i(snp_cd_valid), .snp_cd_ready_o(snp_cd_ready), .snp_cd_data_i(snp_cd_data),
    .mem_ar_valid_o(mem_ar_valid), .mem_ar_ready_i(mem_ar_ready), .mem_ar_addr_o(mem_ar_addr),
    .mem_r_valid_i(mem_r_valid), .mem_r_ready_o(mem_r_ready), .mem_r_data_i(mem_r_data)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
    return {a[AW-1:6], 6'b0};
  endfunction

  function automatic logic [DW-1:0] beat_of(input logic [AW-1:0] a, input int b, input bit hit);
    return {hit ? 32'h5EED_0000 : 32'hD3A0_0000, 32'(b), a[31:0], ~a[31:0]};
  endfunction

  // one complete coherent read; hold keeps a next request pending throughout
  task automatic do_read(input logic [AW-1:0] addr, input bit hit, input bit err,
                         input bit bp, input bit hold, input logic [AW-1:0] next);
    logic [AW-1:0] line = line_of(addr);
    @(negedge clk);
    req_ar_valid = 1; req_ar_addr = addr; #1;
    chk(req_ar_ready == 1, "R7 ready in idle", DW'(req_ar_ready), 1);
    @(negedge clk);
    if (hold) req_ar_addr = next; else req_ar_valid = 0;
    #1;
    chk(req_ar_ready == 0, "R7 busy after accept", DW'(req_ar_ready), 0);
    chk(snp_ac_valid && snp_ac_addr == line, "R2 snoop addr", DW'(snp_ac_addr), DW'(line));
    @(negedge clk); #1;
    chk(snp_ac_valid && snp_ac_addr == line, "R2 snoop addr held", DW'(snp_ac_addr), DW'(line));
    snp_ac_ready = 1;
    @(negedge clk);
    snp_ac_ready = 0; snp_cr_valid = 1; snp_cr_resp = {err, hit}; #1;
    chk(snp_cr_ready == 1, "R3 snoop resp ready", DW'(snp_cr_ready), 1);
    @(negedge clk);
    snp_cr_valid = 0; #1;
    if (!hit) begin
      chk(mem_ar_valid && mem_ar_addr == line, "R4 mem addr", DW'(mem_ar_addr), DW'(line));
      @(negedge clk); #1;
      chk(mem_ar_valid && mem_ar_addr == line, "R9 mem addr held", DW'(mem_ar_addr), DW'(line));
      mem_ar_ready = 1;
      @(negedge clk);
      mem_ar_ready = 0;
    end
    for (int b = 0; b < 4; b++) begin
      logic [DW-1:0] exp = beat_of(addr, b, hit);
      if (hit) begin
        snp_cd_valid = 1; snp_cd_data = exp; mem_r_valid = 1; mem_r_data = ~exp;
      end else begin
        mem_r_valid = 1; mem_r_data = exp; snp_cd_valid = 1; snp_cd_data = ~exp;
      end
      req_r_ready = !(bp && b == 1);
      #1;
      if (bp && b == 1) begin
        chk(!snp_cd_ready && !mem_r_ready, "R8 source stalled", DW'({snp_cd_ready, mem_r_ready}), 0);
        chk(req_r_valid && req_r_data == exp, "R8 beat shown", req_r_data, exp);
        @(negedge clk); #1;
        chk(req_r_valid && req_r_data == exp, "R8 beat held", req_r_data, exp);
        req_r_ready = 1; #1;
      end
      chk(req_r_valid && req_r_data == exp, hit ? "R3 hit data" : "R4 miss data", req_r_data, exp);
      chk(req_r_last == (b == 3), "R5 last flag", DW'(req_r_last), DW'(b == 3));
      chk(req_r_resp == ((b == 3 && err) ? 2'b10 : 2'b00), "R6 resp code", DW'(req_r_resp),
          DW'((b == 3 && err) ? 2'b10 : 2'b00));
      chk(req_ar_ready == 0, "R7 busy during data", DW'(req_ar_ready), 0);
      if (hit) chk(mem_ar_valid == 0 && mem_r_ready == 0, "R3 memory untouched",
                   DW'({mem_ar_valid, mem_r_ready}), 0);
      else     chk(snp_cd_ready == 0, "R4 snoop data ignored", DW'(snp_cd_ready), 0);
      @(negedge clk);
    end
    snp_cd_valid = 0; mem_r_valid = 0; req_r_ready = 0; #1;
    chk(req_ar_ready == 0 && req_r_valid == 0, "R7 turnaround cycle",
        DW'({req_ar_ready, req_r_valid}), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!snp_ac_valid && !mem_ar_valid && !req_r_valid, "R1 valids low in reset",
        DW'({snp_ac_valid, mem_ar_valid, req_r_valid}), 0);
    @(negedge clk); rst_n = 1; #1;
    chk(req_ar_ready && !snp_ac_valid && !mem_ar_valid && !req_r_valid, "R1 state after reset",
        DW'({req_ar_ready, snp_ac_valid, mem_ar_valid, req_r_valid}), DW'(4'b1000));
  endtask

  task automatic t_hit();       do_read(40'h12_3456_7891, 1, 0, 0, 0, '0); endtask
  task automatic t_miss();      do_read(40'h00_0000_10FF, 0, 0, 0, 0, '0); endtask
  task automatic t_hit_bp();    do_read(40'hAB_CDEF_0040, 1, 0, 1, 0, '0); endtask
  task automatic t_miss_bp();   do_read(40'h7F_0000_003F, 0, 0, 1, 0, '0); endtask
  task automatic t_hit_err();   do_read(40'h01_0203_0405, 1, 1, 0, 0, '0); endtask
  task automatic t_miss_err();  do_read(40'hFF_FFFF_FFFF, 0, 1, 0, 0, '0); endtask
  task automatic t_overlap();
    do_read(40'h55_5555_5500, 1, 0, 0, 1, 40'h66_6666_66C7);
    do_read(40'h66_6666_66C7, 0, 0, 0, 0, '0);
  endtask

  initial begin
    t_reset();
    t_hit();
    t_miss();
    t_hit_bp();
    t_miss_bp();
    t_hit_err();
    t_miss_err();
    t_overlap();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule